// File: doc/BRIEF.md
# Interrupt Entry Stack Sequencer

This block carries out the hardware part of taking an interrupt or trap on a small 16-bit processor core. A pending request waits until the core signals that the instruction in progress has finished. The block then captures the program counter, the status word, the stack pointer and the page-zero mode flag. It pushes the context onto a downward-growing stack through a word-wide data memory write port. Last, it issues three instruction fetch requests at the service routine's vector address.

The save phase has a fixed, slot-based schedule. Each pushed word gets a 4-clock slot on top of an 11-clock base. A full three-word frame therefore saves in 23 clocks, and the short two-word frame used in page-zero mode saves in 19 clocks. A 3-clock prefetch phase follows. The worst-case time from request to service routine entry can be checked cycle by cycle. A request that arrives while a sequence is running is kept pending and is taken no earlier than the closing cycle of that sequence.

Top module: `irq_entry_seq`

## Requirements
- R1: A request (a new `irq_req` pulse or one already pending) is accepted only on a clock edge where `instr_done` is high and the block is idle or in its done cycle. `busy` rises in the cycle after that edge, and `instr_done` alone never starts a sequence.
- R2: With `page0`=1 the program counter is pushed as one word, `cur_pc[15:0]`. With `page0`=0 it is pushed as two words: first `cur_pc[15:0]`, then the upper PC bits zero-extended to 16 bits.
- R3: The status word is always the last word pushed.
- R4: Pushed word i (counting from 0) goes to address `cur_sp - 2*(i+1)`. `sp_new` drops by 2 after each write and ends at `cur_sp - 2*words`.
- R5: Word i is written, with a single-cycle `mem_we`, in save cycle 4*i. Save cycle 0 is the cycle right after acceptance.
- R6: The save phase lasts 23 cycles for a three-word frame and 19 cycles for a two-word frame.
- R7: The prefetch phase lasts 3 cycles, with `fetch_req` high and `fetch_addr` equal to V, V+2 and V+4. V is `vec_addr` sampled on the edge that ends the save phase. `pc_new` shows V from the done cycle onward.
- R8: `busy` stays high without a gap from acceptance through the last prefetch cycle: 26 cycles for a three-word frame, 22 for a two-word frame. `done` is then high for exactly one cycle, with `busy` low.
- R9: When `instr_done` arrives at most 24 cycles after the request edge, `done` is high no later than 50 cycles after that edge.
- R10: A request pulsed while `busy` is high is held. If `instr_done` is high, it is accepted on the edge that ends the done cycle, so the next sequence starts directly after `done`.
- R11: `cur_pc`, `cur_psw`, `cur_sp` and `page0` are sampled only at acceptance. Later changes have no effect on the frame being saved.
- R12: After reset `busy`, `done`, `mem_we` and `fetch_req` are low, and `sp_new` and `pc_new` are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| irq_req | input | 1 | Request pulse from the interrupt arbiter |
| instr_done | input | 1 | Instruction-complete strobe from the core |
| page0 | input | 1 | Page-zero mode: 1 pushes a one-word PC |
| cur_pc | input | 24 | Program counter of the interrupted code |
| cur_psw | input | 16 | Processor status word |
| cur_sp | input | 16 | Stack pointer before entry |
| vec_addr | input | 24 | Service routine start address |
| busy | output | 1 | Entry sequence in progress |
| done | output | 1 | One-cycle pulse marking service routine entry |
| mem_we | output | 1 | Data memory write strobe |
| mem_addr | output | 16 | Data memory write address |
| mem_wdata | output | 16 | Data memory write word |
| fetch_req | output | 1 | Program fetch request |
| fetch_addr | output | 24 | Program fetch address |
| sp_new | output | 16 | Updated stack pointer |
| pc_new | output | 24 | New program counter |

## Verification
The assertions assume that `instr_done` is a clean strobe from the core and that the stack pointer does not wrap below zero during a frame. The stimulus meets both assumptions: every stack pointer it uses lies well above the frame size, and it never releases reset in the middle of a sequence. The sweep covers both frame sizes and every completion delay from 0 to 24 cycles. It changes every context input right after acceptance and pulses a second request inside a running sequence.

// File: rtl/irq_entry_pkg.sv
package irq_entry_pkg;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_SAVE = 2'd1,
        ST_PREF = 2'd2,
        ST_DONE = 2'd3
    } ent_state_e;

    localparam int unsigned FULL_WORDS  = 3;
    localparam int unsigned SHORT_WORDS = 2;

endpackage

// File: rtl/irq_entry_pend.sv
module irq_entry_pend (
    input  logic clk,
    input  logic rst_n,
    input  logic irq_req,
    input  logic instr_done,
    input  logic can_accept,
    output logic accept,
    output logic pending
);
    logic pend_d, pend_q;

    always_comb begin
        accept = (irq_req | pend_q) & instr_done & can_accept;
        pend_d = (pend_q | irq_req) & ~accept;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) pend_q <= 1'b0;
        else        pend_q <= pend_d;
    end

    assign pending = pend_q;
endmodule

// File: rtl/irq_entry_frame.sv
module irq_entry_frame #(
    parameter int unsigned PC_W = 24,
    parameter int unsigned DW   = 16
) (
    input  logic [PC_W-1:0] pc,
    input  logic [DW-1:0]   psw,
    input  logic            pg0,
    input  logic [1:0]      idx,
    output logic [DW-1:0]   word,
    output logic [1:0]      nwords
);
    logic [DW-1:0] hi_word;

    generate
        if (PC_W < 2 * DW) begin : g_pad
            assign hi_word = {{(2*DW-PC_W){1'b0}}, pc[PC_W-1:DW]};
        end else begin : g_full
            assign hi_word = pc[2*DW-1:DW];
        end
    endgenerate

    always_comb begin
        nwords = pg0 ? 2'(irq_entry_pkg::SHORT_WORDS) : 2'(irq_entry_pkg::FULL_WORDS);
        word   = psw;
        case (idx)
            2'd0:    word = pc[DW-1:0];
            2'd1:    word = pg0 ? psw : hi_word;
            default: word = psw;
        endcase
    end
endmodule

// File: rtl/irq_entry_slot.sv
module irq_entry_slot #(
    parameter int unsigned SAVE_BASE = 11,
    parameter int unsigned WORD_CYC  = 4,
    parameter int unsigned CW        = 5
) (
    input  logic [CW-1:0] cnt,
    input  logic [1:0]    widx,
    input  logic [1:0]    nwords,
    output logic          write_slot,
    output logic          save_last
);
    localparam logic [CW-1:0] WC = CW'(WORD_CYC);
    localparam logic [CW-1:0] SB = CW'(SAVE_BASE);

    logic [CW-1:0] slot_at;
    logic [CW-1:0] save_len;

    always_comb begin
        slot_at    = {{(CW-2){1'b0}}, widx} * WC;
        save_len   = SB + {{(CW-2){1'b0}}, nwords} * WC;
        write_slot = (widx < nwords) && (cnt == slot_at);
        save_last  = (cnt == save_len - CW'(1));
    end
endmodule

// File: rtl/irq_entry_seq.sv
module irq_entry_seq #(
    parameter int unsigned PC_W      = 24,
    parameter int unsigned DW        = 16,
    parameter int unsigned AW        = 16,
    parameter int unsigned SAVE_BASE = 11,
    parameter int unsigned WORD_CYC  = 4,
    parameter int unsigned PF_CYC    = 3
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            irq_req,
    input  logic            instr_done,
    input  logic            page0,
    input  logic [PC_W-1:0] cur_pc,
    input  logic [DW-1:0]   cur_psw,
    input  logic [AW-1:0]   cur_sp,
    input  logic [PC_W-1:0] vec_addr,
    output logic            busy,
    output logic            done,
    output logic            mem_we,
    output logic [AW-1:0]   mem_addr,
    output logic [DW-1:0]   mem_wdata,
    output logic            fetch_req,
    output logic [PC_W-1:0] fetch_addr,
    output logic [AW-1:0]   sp_new,
    output logic [PC_W-1:0] pc_new
);
    import irq_entry_pkg::*;

    localparam int unsigned MAX_RUN = SAVE_BASE + FULL_WORDS * WORD_CYC + PF_CYC;
    localparam int unsigned CW      = $clog2(MAX_RUN + 1);
    localparam logic [CW-1:0] PF_LAST = CW'(PF_CYC - 1);
    localparam logic [AW-1:0] STEP    = AW'(2);

    typedef struct packed {
        ent_state_e      st;
        logic [CW-1:0]   cnt;
        logic [1:0]      widx;
        logic            pg;
        logic [AW-1:0]   sp;
        logic [PC_W-1:0] pc;
        logic [DW-1:0]   psw;
        logic [PC_W-1:0] vec;
        logic [PC_W-1:0] pcn;
    } seq_regs_t;

    seq_regs_t r_d, r_q;

    logic          can_accept, accept, pending;
    logic [DW-1:0] frame_word;
    logic [1:0]    nwords;
    logic          write_slot, save_last;

    irq_entry_pend u_pend (
        .clk        (clk),
        .rst_n      (rst_n),
        .irq_req    (irq_req),
        .instr_done (instr_done),
        .can_accept (can_accept),
        .accept     (accept),
        .pending    (pending)
    );

    irq_entry_frame #(.PC_W(PC_W), .DW(DW)) u_frame (
        .pc     (r_q.pc),
        .psw    (r_q.psw),
        .pg0    (r_q.pg),
        .idx    (r_q.widx),
        .word   (frame_word),
        .nwords (nwords)
    );

    irq_entry_slot #(.SAVE_BASE(SAVE_BASE), .WORD_CYC(WORD_CYC), .CW(CW)) u_slot (
        .cnt        (r_q.cnt),
        .widx       (r_q.widx),
        .nwords     (nwords),
        .write_slot (write_slot),
        .save_last  (save_last)
    );

    assign can_accept = (r_q.st == ST_IDLE) || (r_q.st == ST_DONE);

    always_comb begin
        r_d = r_q;
        case (r_q.st)
            ST_SAVE: begin
                if (write_slot) begin
                    r_d.sp   = r_q.sp - STEP;
                    r_d.widx = r_q.widx + 2'd1;
                end
                if (save_last) begin
                    r_d.st  = ST_PREF;
                    r_d.cnt = '0;
                    r_d.vec = vec_addr;
                end else begin
                    r_d.cnt = r_q.cnt + CW'(1);
                end
            end
            ST_PREF: begin
                if (r_q.cnt == PF_LAST) begin
                    r_d.st  = ST_DONE;
                    r_d.cnt = '0;
                    r_d.pcn = r_q.vec;
                end else begin
                    r_d.cnt = r_q.cnt + CW'(1);
                end
            end
            ST_DONE: r_d.st = ST_IDLE;
            default: r_d.st = ST_IDLE;
        endcase
        if (accept) begin
            r_d.st   = ST_SAVE;
            r_d.cnt  = '0;
            r_d.widx = 2'd0;
            r_d.pg   = page0;
            r_d.sp   = cur_sp;
            r_d.pc   = cur_pc;
            r_d.psw  = cur_psw;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            r_q.st   <= ST_IDLE;
            r_q.cnt  <= '0;
            r_q.widx <= 2'd0;
            r_q.pg   <= 1'b0;
            r_q.sp   <= '0;
            r_q.pc   <= '0;
            r_q.psw  <= '0;
            r_q.vec  <= '0;
            r_q.pcn  <= '0;
        end else begin
            r_q <= r_d;
        end
    end

    always_comb begin
        busy       = (r_q.st == ST_SAVE) || (r_q.st == ST_PREF);
        done       = (r_q.st == ST_DONE);
        mem_we     = (r_q.st == ST_SAVE) && write_slot;
        mem_addr   = r_q.sp - STEP;
        mem_wdata  = frame_word;
        fetch_req  = (r_q.st == ST_PREF);
        fetch_addr = r_q.vec + {{(PC_W-CW-1){1'b0}}, r_q.cnt, 1'b0};
        sp_new     = r_q.sp;
        pc_new     = r_q.pcn;
    end
endmodule

// File: rtl/irq_entry_seq_chk.sv
module irq_entry_seq_chk #(
    parameter int unsigned AW        = 16,
    parameter int unsigned SAVE_BASE = 11,
    parameter int unsigned WORD_CYC  = 4,
    parameter int unsigned PF_CYC    = 3
) (
    input logic          clk,
    input logic          rst_n,
    input logic          instr_done,
    input logic          busy,
    input logic          done,
    input logic          mem_we,
    input logic          fetch_req,
    input logic [AW-1:0] sp_new
);
    localparam int unsigned LONG_RUN  = SAVE_BASE + 3 * WORD_CYC + PF_CYC;
    localparam int unsigned SHORT_RUN = SAVE_BASE + 2 * WORD_CYC + PF_CYC;

    logic [7:0] run_q;
    logic       busy_prev_q;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            run_q       <= 8'd0;
            busy_prev_q <= 1'b0;
        end else begin
            busy_prev_q <= busy;
            if (busy) run_q <= busy_prev_q ? run_q + 8'd1 : 8'd1;
        end
    end

    p_accept_needs_done_r1: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(busy) |-> $past(instr_done));
    p_sp_step_r4: assert property (@(posedge clk) disable iff (!rst_n)
        mem_we |=> sp_new == $past(sp_new) - AW'(2));
    p_write_in_busy_r5: assert property (@(posedge clk) disable iff (!rst_n)
        mem_we |-> busy && !fetch_req);
    p_fetch_before_done_r7: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> $past(fetch_req));
    p_done_single_r8: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);
    p_done_not_busy_r8: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> !busy);
    p_run_length_r8: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> (run_q == 8'(LONG_RUN)) || (run_q == 8'(SHORT_RUN)));
endmodule

bind irq_entry_seq irq_entry_seq_chk #(
    .AW(AW), .SAVE_BASE(SAVE_BASE), .WORD_CYC(WORD_CYC), .PF_CYC(PF_CYC)
) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .instr_done (instr_done),
    .busy       (busy),
    .done       (done),
    .mem_we     (mem_we),
    .fetch_req  (fetch_req),
    .sp_new     (sp_new)
);

// File: tb/test_irq_entry_seq.sv
`timescale 1ns/1ps
module test_irq_entry_seq;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        irq_req = 1'b0, instr_done = 1'b0, page0 = 1'b0;
    logic [23:0] cur_pc = '0, vec_addr = '0;
    logic [15:0] cur_psw = '0, cur_sp = '0;
    logic        busy, done, mem_we, fetch_req;
    logic [15:0] mem_addr, mem_wdata, sp_new;
    logic [23:0] fetch_addr, pc_new;

    int n_chk = 0;
    int n_bad = 0;
    logic [15:0] prev_sp = '0;
    logic [23:0] prev_pc = '0;

    always #2 clk = ~clk;

    irq_entry_seq i_irq_entry_seq (
        .clk(clk), .rst_n(rst_n), .irq_req(irq_req), .instr_done(instr_done),
        .page0(page0), .cur_pc(cur_pc), .cur_psw(cur_psw), .cur_sp(cur_sp),
        .vec_addr(vec_addr), .busy(busy), .done(done), .mem_we(mem_we),
        .mem_addr(mem_addr), .mem_wdata(mem_wdata), .fetch_req(fetch_req),
        .fetch_addr(fetch_addr), .sp_new(sp_new), .pc_new(pc_new)
    );

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: got %0h expected %0h", tag, act, exp);
        end
    endtask

    function automatic logic [15:0] frame_word(input int i, input int n,
                                               input logic [23:0] pc, input logic [15:0] psw);
        if (i == 0)     return pc[15:0];
        if (i == n - 1) return psw;
        return {8'h00, pc[23:16]};
    endfunction

    task automatic run_trial(input bit pg, input int d, input bit b2b);
        logic [23:0] pc0, vec0;
        logic [15:0] psw0, sp0, scr_sp;
        int n, len, m, wcnt, run, n2;
        pc0    = 24'hA00000 ^ 24'(d * 24'h01357B) ^ (pg ? 24'h000003 : 24'h0);
        psw0   = 16'h8000 | 16'(d * 16'h0111);
        sp0    = 16'h4000 + 16'(d * 16'h0020) + (pg ? 16'h0100 : 16'h0);
        vec0   = 24'h000100 + 24'(d * 8);
        scr_sp = sp0 ^ 16'h0F0E;
        n      = pg ? 2 : 3;
        len    = 11 + 4 * n;
        @(negedge clk);
        cur_pc = pc0; cur_psw = psw0; cur_sp = sp0; page0 = pg; vec_addr = vec0;
        irq_req = 1'b1; instr_done = (d == 0);
        for (int k = 0; k <= d + len + 3; k++) begin
            @(negedge clk);
            m = k - d;
            check(m == 0 ? "R1 busy" : "R8 busy", 32'(busy), 32'(m >= 0 && m <= len + 2));
            check("R8 done", 32'(done), 32'(m == len + 3));
            wcnt = 0;
            for (int i = 0; i < n; i++) if (m >= 0 && 4 * i < m) wcnt++;
            check("R4 sp_new", 32'(sp_new), 32'(m < 0 ? prev_sp : sp0 - 16'(2 * wcnt)));
            begin
                bit we_exp = 1'b0;
                for (int i = 0; i < n; i++) begin
                    if (m == 4 * i) begin
                        we_exp = 1'b1;
                        check("R4 mem_addr", 32'(mem_addr), 32'(sp0 - 16'(2 * (i + 1))));
                        check(i == n - 1 ? "R3 R11 psw word" : "R2 R11 pc word",
                              32'(mem_wdata), 32'(frame_word(i, n, pc0, psw0)));
                    end
                end
                check("R5 mem_we", 32'(mem_we), 32'(we_exp));
            end
            check(m == len ? "R6 fetch start" : "R7 fetch_req", 32'(fetch_req),
                  32'(m >= len && m <= len + 2));
            if (m >= len && m <= len + 2)
                check("R7 fetch_addr", 32'(fetch_addr), 32'(vec0 + 24'(2 * (m - len))));
            check("R7 pc_new", 32'(pc_new), 32'(m >= len + 3 ? vec0 : prev_pc));
            if (m == len + 3) check("R9 latency", 32'(k <= 50), 32'd1);
            irq_req    = b2b && (k + 1 == d + 5);
            instr_done = (k + 1 == d) || (b2b && k + 1 >= d + 6);
            if (k + 1 > d) begin
                cur_pc = ~pc0; cur_psw = ~psw0; cur_sp = scr_sp; page0 = ~pg;
            end
        end
        prev_sp = sp0 - 16'(2 * n);
        prev_pc = vec0;
        if (b2b) begin
            n2 = pg ? 3 : 2;
            @(negedge clk);
            check("R10 busy", 32'(busy), 32'd1);
            check("R10 mem_we", 32'(mem_we), 32'd1);
            check("R10 mem_addr", 32'(mem_addr), 32'(scr_sp - 16'd2));
            instr_done = 1'b0;
            run = 1;
            for (int g = 0; g < 40; g++) begin
                @(negedge clk);
                if (done) break;
                run++;
            end
            check("R8 R10 second run", 32'(run), 32'(11 + 4 * n2 + 3));
            prev_sp = scr_sp - 16'(2 * n2);
        end
        irq_req = 1'b0; instr_done = 1'b0;
        repeat (2) @(negedge clk);
        check("R1 idle after", 32'(busy), 32'd0);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_bad++;
        $display("FAIL watchdog: got %0d expected %0d", n_chk, 0);
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        check("R12 busy", 32'(busy), 32'd0);
        check("R12 done", 32'(done), 32'd0);
        check("R12 mem_we", 32'(mem_we), 32'd0);
        check("R12 fetch_req", 32'(fetch_req), 32'd0);
        check("R12 sp_new", 32'(sp_new), 32'd0);
        check("R12 pc_new", 32'(pc_new), 32'd0);
        instr_done = 1'b1;
        for (int k = 0; k < 6; k++) begin
            @(negedge clk);
            check("R1 done alone", 32'(busy), 32'd0);
        end
        instr_done = 1'b0;
        for (int p = 0; p < 2; p++)
            for (int d = 0; d <= 24; d++)
                run_trial(p[0], d, 1'b0);
        run_trial(1'b0, 2, 1'b1);
        run_trial(1'b1, 7, 1'b1);
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end
endmodule